// File: doc/BRIEF.md
# SWD Line-Reset and Select-Sequence Detector

This block watches the synchronized serial-wire debug clock and data samples, one pair per system clock, alongside a transaction decoder but without depending on its state. On every rising edge of the sampled debug clock it counts how many edges in a row have found the data line high. It also keeps a short history of the sampled bits. From these it recognises two events. The first is a line reset: a long run of high bits ended by a low bit. The second is the 16-bit JTAG-to-SWD select sequence, sent least significant bit first.

Each event raises a one-cycle pulse that the transaction decoder uses to return to its wait-for-request state. With the reset pulse the block reports the length of the high run, saturated at the counter width. The decoder pulses `phase_adv` each time it enters a new phase, which clears the run count. A strict-mode input keeps `decode_en` low after reset until the first line reset has been seen. When that input is low, decoding is enabled at once.

Top module: `swd_linereset_det`

## Requirements
- R1: After reset, `line_rst_pulse` and `sel_pulse` are 0, `rst_len` is 0, and `decode_en` equals the inverse of `strict_mode`.
- R2: A rising edge of `swclk_s` (1 in this cycle, 0 in the previous) that samples `swdio_s` low, after at least MIN_HIGH (default 50) consecutive rising edges that sampled it high, makes `line_rst_pulse` 1 for exactly the cycle after that edge.
- R3: A high run shorter than MIN_HIGH edges (for example 49) that is ended by a low edge produces no `line_rst_pulse`. Each low edge restarts the run from zero.
- R4: While `line_rst_pulse` is 1, `rst_len` gives the number of high edges in the run, saturated at 2^CNT_W-1 (255 by default). Changes on `swdio_s` between rising edges do not alter the count.
- R5: A `phase_adv` cycle clears the run count, so high edges before it do not count toward a line reset.
- R6: When the last 16 sampled bits, oldest first, equal bits 0 to 15 of 0xE79E, `sel_pulse` is 1 for the cycle after the edge that completes them. The same bits sent most significant bit first give no pulse.
- R7: With `strict_mode` held at 1, `decode_en` stays 0 until the first line reset pulse and then stays 1. With `strict_mode` at 0 it stays 1.
- R8: Each pulse lasts one cycle, and the two pulses are never high in the same cycle.
- R9: After a select match the bit history counts as empty. Two back-to-back select sequences therefore give two pulses, and a further match needs 16 new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_mode | input | 1 | 1: hold decoding off until the first line reset (held static) |
| swclk_s | input | 1 | Synchronized debug clock sample |
| swdio_s | input | 1 | Synchronized debug data sample |
| phase_adv | input | 1 | Decoder entered a new phase; clears the run count |
| line_rst_pulse | output | 1 | One-cycle line reset indication |
| sel_pulse | output | 1 | One-cycle select-sequence indication |
| rst_len | output | CNT_W | High-run length captured at the last line reset |
| decode_en | output | 1 | Decoder may interpret traffic |

## Verification
Some properties can be checked on every cycle. The assertions check that the pulses are single-cycle and never coincide. They check that a line reset pulse always follows a low rising edge, and that its reported length reaches the threshold. They also check that strict-mode enable never drops once it has risen. Whether a given bit stream should have produced a reset or a select match cannot be judged cycle by cycle. The bench covers that with random high runs on both sides of the threshold, saturating runs, phase-advance clears, data wiggles between edges, and reversed and repeated select patterns. All of these are compared against a bit-level reference model.

// File: rtl/swd_lrd_pkg.sv
package swd_lrd_pkg;

    localparam int SEL_W = 16;

    // Reverse a select-width word: the first transmitted bit ends up as MSB
    function automatic logic [SEL_W-1:0] rev_sel(input logic [SEL_W-1:0] v);
        logic [SEL_W-1:0] r;
        for (int i = 0; i < SEL_W; i++) begin
            r[i] = v[SEL_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/swd_lrd_edge.sv
module swd_lrd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic swclk_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = swclk_i;
        rise_o = swclk_i & ~prev_q;
    end

    // Reset high so a clock already high after reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/swd_lrd_runcnt.sv
module swd_lrd_runcnt #(
    parameter int CNT_W    = 8,
    parameter int MIN_HIGH = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             dio_i,
    input  logic             clr_i,
    output logic             pulse_o,
    output logic [CNT_W-1:0] len_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_HIGH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             pulse;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (rise_i) begin
            if (dio_i) begin
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                if (st_q.cnt >= MIN_L) begin
                    st_d.pulse = 1'b1;
                    st_d.len   = st_q.cnt;
                end
                st_d.cnt = '0;
            end
        end
        if (clr_i) st_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign len_o   = st_q.len;
endmodule

// File: rtl/swd_lrd_selmatch.sv
module swd_lrd_selmatch
    import swd_lrd_pkg::*;
#(
    parameter logic [SEL_W-1:0] PATTERN = 16'hE79E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic dio_i,
    output logic pulse_o
);
    localparam int               FILL_W = $clog2(SEL_W + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SEL_W);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SEL_W - 1);
    localparam logic [SEL_W-1:0]  TARGET    = rev_sel(PATTERN);

    typedef struct packed {
        logic [SEL_W-1:0]  hist;
        logic [FILL_W-1:0] fill;
        logic              pulse;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (rise_i) begin
            st_d.hist = {st_q.hist[SEL_W-2:0], dio_i};
            if (st_q.fill != FILL_FULL) st_d.fill = st_q.fill + 1'b1;
            if (st_q.fill >= FILL_LAST && st_d.hist == TARGET) begin
                st_d.pulse = 1'b1;
                st_d.fill  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/swd_linereset_det.sv
module swd_linereset_det
    import swd_lrd_pkg::*;
#(
    parameter int               CNT_W    = 8,
    parameter int               MIN_HIGH = 50,
    parameter logic [SEL_W-1:0] SEL_PAT  = 16'hE79E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strict_mode,
    input  logic             swclk_s,
    input  logic             swdio_s,
    input  logic             phase_adv,
    output logic             line_rst_pulse,
    output logic             sel_pulse,
    output logic [CNT_W-1:0] rst_len,
    output logic             decode_en
);
    logic rise;
    logic armed_d, armed_q;

    swd_lrd_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .swclk_i (swclk_s),
        .rise_o  (rise)
    );

    swd_lrd_runcnt #(
        .CNT_W    (CNT_W),
        .MIN_HIGH (MIN_HIGH)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .dio_i   (swdio_s),
        .clr_i   (phase_adv),
        .pulse_o (line_rst_pulse),
        .len_o   (rst_len)
    );

    swd_lrd_selmatch #(
        .PATTERN (SEL_PAT)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .dio_i   (swdio_s),
        .pulse_o (sel_pulse)
    );

    always_comb begin
        armed_d   = armed_q | line_rst_pulse;
        decode_en = ~strict_mode | armed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/swd_lrd_chk.sv
module swd_lrd_chk #(
    parameter int CNT_W    = 8,
    parameter int MIN_HIGH = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strict_mode,
    input logic             swclk_s,
    input logic             swdio_s,
    input logic             line_rst_pulse,
    input logic             sel_pulse,
    input logic [CNT_W-1:0] rst_len,
    input logic             decode_en
);
    // R8
    rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst_pulse |=> !line_rst_pulse);

    // R8
    sel_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pulse |=> !sel_pulse);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_rst_pulse && sel_pulse));

    // R2
    rst_after_low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst_pulse |-> ($past(swclk_s) && !$past(swdio_s) && !$past(swclk_s, 2)));

    // R4
    len_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst_pulse |-> (32'(rst_len) >= MIN_HIGH));

    // R7
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && decode_en) |=> (decode_en || !strict_mode));

    // R7
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strict_mode && $past(strict_mode) && $rose(decode_en)) |-> $past(line_rst_pulse));
endmodule

bind swd_linereset_det swd_lrd_chk #(
    .CNT_W    (CNT_W),
    .MIN_HIGH (MIN_HIGH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strict_mode    (strict_mode),
    .swclk_s        (swclk_s),
    .swdio_s        (swdio_s),
    .line_rst_pulse (line_rst_pulse),
    .sel_pulse      (sel_pulse),
    .rst_len        (rst_len),
    .decode_en      (decode_en)
);

// File: tb/swd_linereset_det_test.sv
`timescale 1ns/1ps
module swd_linereset_det_test;
    localparam int          CNT_W = 8;
    localparam int          MINH  = 50;
    localparam logic [15:0] PAT   = 16'hE79E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strict_mode = 1'b0;
    logic swclk = 1'b0;
    logic swdio = 1'b0;
    logic phase_adv = 1'b0;
    logic line_rst_pulse, sel_pulse, decode_en;
    logic [CNT_W-1:0] rst_len;

    always #2.5 clk = ~clk;

    swd_linereset_det uut (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
        .swclk_s(swclk), .swdio_s(swdio), .phase_adv(phase_adv),
        .line_rst_pulse(line_rst_pulse), .sel_pulse(sel_pulse),
        .rst_len(rst_len), .decode_en(decode_en)
    );

    int tests = 0, fails = 0;
    int seen_rst = 0, seen_sel = 0, bad_r8 = 0;
    int exp_rst = 0, exp_sel = 0;
    int cnt = 0, fill = 0, exp_len = 0;
    logic [CNT_W-1:0] seen_len = '0;
    logic [15:0] hist = '0;
    bit armed = 0;
    bit prev_lr = 0, prev_sp = 0;
    bit done = 0;

    function automatic logic [15:0] reverse16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[15-i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (line_rst_pulse) begin seen_rst++; seen_len = rst_len; end
            if (sel_pulse) seen_sel++;
            if ((line_rst_pulse && sel_pulse) || (line_rst_pulse && prev_lr) || (sel_pulse && prev_sp))
                bad_r8++;
            prev_lr = line_rst_pulse;
            prev_sp = sel_pulse;
        end else begin
            prev_lr = 0;
            prev_sp = 0;
        end
    end

    task automatic model_bit(input logic d, input bit adv);
        if (adv) cnt = 0;
        if (d) begin
            if (cnt < 255) cnt++;
        end else begin
            if (cnt >= MINH) begin exp_rst++; exp_len = cnt; armed = 1; end
            cnt = 0;
        end
        hist = {hist[14:0], d};
        if (fill < 16) fill++;
        if (fill == 16 && hist == reverse16(PAT)) begin exp_sel++; fill = 0; end
    endtask

    task automatic send_bit(input logic d, input bit adv);
        int r0;
        r0 = exp_rst;
        @(negedge clk); swclk = 1'b0; swdio = d; phase_adv = adv;
        @(negedge clk); phase_adv = 1'b0;
        @(negedge clk); swclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_bit(d, adv);
        check("R2/R3 line reset count", seen_rst, exp_rst);
        check("R6/R9 select count", seen_sel, exp_sel);
        if (exp_rst != r0) check("R4 reset length", int'(seen_len), exp_len);
        check("R7 decode_en", int'(decode_en), int'(!strict_mode || armed));
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 0);
    endtask

    task automatic send_pat(input logic [15:0] p);
        for (int i = 0; i < 16; i++) send_bit(p[i], 0);
    endtask

    task automatic do_reset(input logic strict);
        rst_n = 1'b0; strict_mode = strict; swclk = 1'b0; swdio = 1'b0;
        seen_rst = 0; seen_sel = 0; exp_rst = 0; exp_sel = 0;
        cnt = 0; fill = 0; hist = '0; armed = 0; seen_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 line_rst_pulse", int'(line_rst_pulse), 0);
        check("R1 sel_pulse", int'(sel_pulse), 0);
        check("R1 rst_len", int'(rst_len), 0);
        check("R1 decode_en", int'(decode_en), int'(!strict));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s;
        void'($urandom(32'd4242));
        do_reset(1'b0);

        // R3: 49 highs then low -> no pulse
        send_run(49); send_bit(1'b0, 0);
        check("R3 short run", seen_rst, 0);
        // R2: exactly 50 highs then low -> one pulse, length 50
        send_run(50); send_bit(1'b0, 0);
        check("R2 threshold run", seen_rst, 1);
        check("R4 length at threshold", int'(seen_len), 50);
        // R4: saturation at 255
        send_run(300); send_bit(1'b0, 0);
        check("R4 saturated length", int'(seen_len), 255);
        // R4: data wiggle while clock held high does not count
        send_run(45);
        repeat (6) begin @(negedge clk); swdio = ~swdio; end
        @(negedge clk); swdio = 1'b1;
        send_bit(1'b0, 0);
        check("R4 wiggle ignored", seen_rst, 2);
        // R5: phase advance clears the count
        send_run(40); send_bit(1'b1, 1); send_run(20); send_bit(1'b0, 0);
        check("R5 cleared by phase_adv", seen_rst, 2);
        // R6: select pattern LSB first; reversed order does not match
        send_bit(1'b0, 0);
        send_pat(PAT);
        check("R6 select match", seen_sel, 1);
        send_pat(reverse16(PAT));
        check("R6 reversed no match", seen_sel, 1);
        // R9: back-to-back patterns
        send_pat(PAT); send_pat(PAT);
        check("R9 back-to-back", seen_sel, 3);

        // random mix
        for (int k = 0; k < 40; k++) begin
            s = $urandom % 4;
            if (s == 0) begin
                send_run(44 + $urandom % 12); send_bit(1'b0, 0);
            end else if (s == 1) begin
                send_pat(PAT);
            end else if (s == 2) begin
                for (int j = 0; j < 8; j++) send_bit(1'($urandom), 1'($urandom % 8 == 0));
            end else begin
                send_run(30 + $urandom % 30); send_bit(1'b1, 1); send_run($urandom % 30); send_bit(1'b0, 0);
            end
        end

        // R7: strict mode
        do_reset(1'b1);
        send_pat(PAT);
        check("R7 select does not enable", int'(decode_en), 0);
        send_run(60); send_bit(1'b0, 0);
        check("R7 enabled after reset", int'(decode_en), 1);
        send_run(10); send_bit(1'b0, 0);
        check("R7 stays enabled", int'(decode_en), 1);

        // R8
        check("R8 pulse shape", bad_r8, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule